// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block keeps the configuration registers of a display engine in two copies. Software reads and writes a staging copy through a simple register port. A second copy is frozen and drives the pixel datapath. The staging copy is transferred into the frozen copy in a single clock cycle. The transfer happens only at the start of vertical blanking, so the datapath never sees a configuration that is half updated in the middle of a frame.

Two modes decide when the transfer happens. These modes are held in a control word at address 0. With the hold bit clear, every start of blanking refreshes the frozen copy on its own. With the hold bit set, the frozen copy changes only after software posts a commit. A commit is a single control write that sets both the hold bit and the commit bit. The commit bit reads back as 1 while the request is outstanding. It drops to 0 on the cycle that performs the transfer, so software can poll it before it starts the next batch of writes. At start-up, software writes the hold bit alone. It then clears every configuration register by writing zeros and posts a first commit.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After synchronous reset, all staging registers, all frozen registers, the hold bit and the commit bit are zero.
- R2: A write to a configuration address (1 to N_REGS) updates the staging register, and the new value reads back on the following cycle. The frozen copy is not changed by the write.
- R3: While the hold bit (control bit 0) is 0, every rising edge of `vblank` copies all staging registers into the frozen copy. No request is needed.
- R4: While the hold bit is 1 and no commit is pending, `vblank` edges leave the frozen copy unchanged.
- R5: A control write with bit 1 set makes the commit bit read 1. At the next rising edge of `vblank`, the clock edge that first samples `vblank` high copies staging into frozen and clears the commit bit.
- R6: Only a low-to-high change of `vblank` triggers a copy. A commit posted while `vblank` is already high waits for the next rising edge.
- R7: A configuration write on the same cycle as a copy goes into staging only. The frozen copy receives the staging value from before that write, and the new value is applied at the following copy.
- R8: A control write with bit 1 set on the same cycle as a copy leaves the commit pending for the next rising edge.
- R9: A control write with bit 1 clear does not cancel a pending commit. Its bit 0 still updates the hold bit.
- R10: Writes to addresses above N_REGS change no register, and reads of those addresses return zero.
- R11: A read of address 0 returns the hold bit in bit 0 and the commit bit in bit 1, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 = control, 1..N_REGS = configuration) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| vblank | input | 1 | Vertical blanking level, synchronous to clk |
| active_cfg | output | N_REGS*DATA_W | Frozen configuration, register k-1 in slice k-1 |

## Verification
The bench aims at the collisions that a cycle-based design can get wrong:
- A configuration write landing on the copy cycle. A design that forwarded the write would place the new value in the frozen copy one frame early.
- A commit posted on the copy cycle. If the clear took priority, the commit would be lost and a polling driver would never see its update.
- A commit issued while `vblank` is already high. A level-triggered design would copy mid-blanking, or on every cycle.
- A control write that clears bit 1 while a commit is pending. A design that treated bit 1 as a plain register field would drop the request.

Out-of-range addresses are also exercised, to catch a decoder that aliases them onto real registers.

// File: rtl/cfg_shadow_pkg.sv
// Package: shared constants and types for the double-buffered register bank.
// Assumes address 0 is the control word and configuration registers follow it.
package cfg_shadow_pkg;
    localparam int CTRL_ADDR    = 0;
    localparam int HOLD_BIT     = 0;
    localparam int COMMIT_BIT   = 1;
    localparam int CTRL_BITS    = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_NONE = 2'd2
    } addr_sel_e;
endpackage

// File: rtl/cfg_vblank_edge.sv
// Module: detects the low-to-high transition of the blanking level.
// Assumes vblank is already synchronous to clk. The pulse is combinational in the
// cycle where vblank is first seen high.
module cfg_vblank_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    output logic vb_rise
);
    logic vb_q;

    // Remember the previous blanking level.
    always_ff @(posedge clk) begin
        if (!rst_n) vb_q <= 1'b0;
        else        vb_q <= vblank;
    end

    // Rising edge when the level is high now and was low before.
    always_comb vb_rise = vblank & ~vb_q;
endmodule

// File: rtl/cfg_commit_ctrl.sv
// Module: holds the hold bit and the self-clearing commit bit, and decides when
// staging is copied into the frozen copy.
// Assumes ctrl_we is asserted only for writes to the control address.
module cfg_commit_ctrl
    import cfg_shadow_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vb_rise,
    input  logic                 ctrl_we,
    input  logic [CTRL_BITS-1:0] ctrl_wd,
    output logic                 hold,
    output logic                 commit_pend,
    output logic                 copy_now
);
    // Copy on a blanking edge when running free or when a commit is pending.
    always_comb copy_now = vb_rise & (~hold | commit_pend);

    // Update the mode bit and the request. A new request wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold        <= 1'b0;
            commit_pend <= 1'b0;
        end else begin
            if (copy_now)
                commit_pend <= 1'b0;
            if (ctrl_we) begin
                hold <= ctrl_wd[HOLD_BIT];
                if (ctrl_wd[COMMIT_BIT])
                    commit_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: staging and frozen storage for N_REGS configuration registers.
// Assumes at most one write enable is set per cycle. A copy takes the staging
// values from before any write in the same cycle.
module cfg_reg_bank #(
    parameter int N_REGS = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REGS-1:0]        reg_we,
    input  logic [DATA_W-1:0]        wd,
    input  logic                     copy_now,
    output logic [N_REGS*DATA_W-1:0] shadow_flat,
    output logic [N_REGS*DATA_W-1:0] active_flat
);
    genvar gi;
    generate
        for (gi = 0; gi < N_REGS; gi++) begin : g_reg
            logic [DATA_W-1:0] stage_q;
            logic [DATA_W-1:0] live_q;

            // Staging register: written by software.
            always_ff @(posedge clk) begin
                if (!rst_n)          stage_q <= '0;
                else if (reg_we[gi]) stage_q <= wd;
            end

            // Frozen register: loaded from staging on a copy cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)        live_q <= '0;
                else if (copy_now) live_q <= stage_q;
            end

            assign shadow_flat[gi*DATA_W +: DATA_W] = stage_q;
            assign active_flat[gi*DATA_W +: DATA_W] = live_q;
        end
    endgenerate
endmodule

// File: rtl/cfg_shadow_bank.sv
// Module: top of the double-buffered configuration bank. Decodes the register
// port, returns staging values or live control status on reads, and drives
// the frozen copy to the datapath.
// Assumes vblank is synchronous to clk and that ADDR_W can address N_REGS+1 words.
module cfg_shadow_bank
    import cfg_shadow_pkg::*;
#(
    parameter int N_REGS = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     vblank,
    output logic [N_REGS*DATA_W-1:0] active_cfg
);
    localparam int TOTAL_W = N_REGS * DATA_W;

    logic              vb_rise;
    logic              hold;
    logic              commit_pend;
    logic              copy_now;
    logic              ctrl_we;
    logic [N_REGS-1:0] reg_we;
    logic [TOTAL_W-1:0] shadow_flat;
    addr_sel_e         wsel;
    addr_sel_e         rsel;

    // Classify an address as control, configuration or unmapped.
    function automatic addr_sel_e classify(input logic [ADDR_W-1:0] a);
        if (a == ADDR_W'(CTRL_ADDR))  return SEL_CTRL;
        else if (int'(a) <= N_REGS)   return SEL_CFG;
        else                          return SEL_NONE;
    endfunction

    // Decode write and read address classes.
    always_comb begin
        wsel = classify(wr_addr);
        rsel = classify(rd_addr);
    end

    // Control write strobe.
    always_comb ctrl_we = wr_en & (wsel == SEL_CTRL);

    // One write enable per configuration register.
    genvar gw;
    generate
        for (gw = 0; gw < N_REGS; gw++) begin : g_we
            assign reg_we[gw] = wr_en & (wr_addr == ADDR_W'(gw + 1));
        end
    endgenerate

    cfg_vblank_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .vblank  (vblank),
        .vb_rise (vb_rise)
    );

    cfg_commit_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .vb_rise     (vb_rise),
        .ctrl_we     (ctrl_we),
        .ctrl_wd     (wr_data[CTRL_BITS-1:0]),
        .hold        (hold),
        .commit_pend (commit_pend),
        .copy_now    (copy_now)
    );

    cfg_reg_bank #(
        .N_REGS (N_REGS),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .wd          (wr_data),
        .copy_now    (copy_now),
        .shadow_flat (shadow_flat),
        .active_flat (active_cfg)
    );

    // Read mux: live status for control, staging for configuration, zero otherwise.
    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_CTRL: begin
                rd_data[HOLD_BIT]   = hold;
                rd_data[COMMIT_BIT] = commit_pend;
            end
            SEL_CFG: begin
                for (int i = 0; i < N_REGS; i++)
                    if (rd_addr == ADDR_W'(i + 1))
                        rd_data = shadow_flat[i*DATA_W +: DATA_W];
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cfg_shadow_chk.sv
// Module: assertion checker for cfg_shadow_bank, attached with bind.
// Assumes it observes internal control state and both register copies.
module cfg_shadow_chk #(
    parameter int N_REGS = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vblank,
    input logic                     vb_rise,
    input logic                     hold,
    input logic                     commit_pend,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [DATA_W-1:0]        rd_data,
    input logic [N_REGS*DATA_W-1:0] shadow_flat,
    input logic [N_REGS*DATA_W-1:0] active_cfg
);
    // R3: a blanking edge in free-running mode loads the prior staging values.
    a_r3_free_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_rise && !hold) |=> (active_cfg == $past(shadow_flat)));

    // R4: held with nothing pending, the frozen copy does not move.
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !commit_pend) |=> $stable(active_cfg));

    // R5: a pending commit clears on the copy edge unless re-posted that cycle.
    a_r5_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pend && vb_rise && !(wr_en && wr_addr == '0 && wr_data[1]))
        |=> !commit_pend);

    // R6: with no rising edge, the frozen copy holds.
    a_r6_level_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!vb_rise) |=> $stable(active_cfg));

    // R8: a commit write always leaves the request pending.
    a_r8_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && wr_data[1]) |=> commit_pend);

    // R10: unmapped addresses read as zero.
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) > N_REGS) |-> (rd_data == '0));

    // R11: the control word has no bits above the commit bit.
    a_r11_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_data[DATA_W-1:2] == '0));

    // R11: the control word read returns the live state bits.
    a_r11_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_data[1:0] == {commit_pend, hold}));

    logic unused_ok;
    assign unused_ok = vblank;
endmodule

bind cfg_shadow_bank cfg_shadow_chk #(
    .N_REGS (N_REGS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vblank      (vblank),
    .vb_rise     (vb_rise),
    .hold        (hold),
    .commit_pend (commit_pend),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .shadow_flat (shadow_flat),
    .active_cfg  (active_cfg)
);

// File: tb/sim_cfg_shadow_bank.sv
`timescale 1ns/1ps
module sim_cfg_shadow_bank;
    localparam int N  = 8;
    localparam int DW = 32;
    localparam int AW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;
    logic [AW-1:0]   rd_addr;
    logic [DW-1:0]   rd_data;
    logic            vblank;
    logic [N*DW-1:0] active_cfg;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    // Reference state, built from the requirements.
    logic [DW-1:0] m_sh  [N];
    logic [DW-1:0] m_act [N];
    logic          m_hold, m_pend, m_vbq;

    always #2 clk = ~clk;

    cfg_shadow_bank #(.N_REGS(N), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .vblank(vblank), .active_cfg(active_cfg)
    );

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        if (a == 0)       return {30'b0, m_pend, m_hold};
        else if (a <= N)  return m_sh[a-1];
        else              return '0;
    endfunction

    task automatic check_eq(input string tag, input string what,
                            input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model, compare after the rising edge.
    task automatic cyc(input string tag, input logic we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input logic vb, input logic [AW-1:0] ra);
        logic rise, copy;
        wr_en = we; wr_addr = wa; wr_data = wd; vblank = vb; rd_addr = ra;
        @(posedge clk);
        rise = vb && !m_vbq;
        copy = rise && (!m_hold || m_pend);
        if (copy) begin
            for (int i = 0; i < N; i++) m_act[i] = m_sh[i];
            m_pend = 1'b0;
        end
        if (we) begin
            if (wa == 0) begin
                m_hold = wd[0];
                if (wd[1]) m_pend = 1'b1;
            end else if (wa <= N) begin
                m_sh[wa-1] = wd;
            end
        end
        m_vbq = vb;
        #1;
        for (int i = 0; i < N; i++)
            check_eq(tag, "active", active_cfg[i*DW +: DW], m_act[i]);
        check_eq(tag, "rd_data", rd_data, exp_read(ra));
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input logic vb, input logic [AW-1:0] ra);
        cyc(tag, 1'b0, '0, '0, vb, ra);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        m_hold = 0; m_pend = 0; m_vbq = 0;
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; vblank = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        idle("R1", 0, 0);
        idle("R1", 0, 3);
        // R11: control word readback masks upper bits
        cyc("R11", 1, 0, 32'hFFFF_FFFD, 0, 0);
        // R2: staging write reads back, frozen untouched
        cyc("R2", 1, 1, 32'hA5A5_0001, 0, 1);
        idle("R2", 0, 1);
        // R4: held, no commit, blanking edge ignored
        idle("R4", 1, 1);
        idle("R4", 0, 1);
        // R5: commit pends until next rising edge, then clears
        cyc("R5", 1, 0, 32'h3, 0, 0);
        idle("R5", 0, 0);
        idle("R5", 1, 0);
        idle("R5", 0, 0);
        // R6: commit posted while blanking is high waits for a new edge
        cyc("R6", 1, 2, 32'h0000_BEEF, 1, 2);
        cyc("R6", 1, 0, 32'h3, 1, 0);
        idle("R6", 1, 0);
        idle("R6", 0, 0);
        idle("R6", 1, 0);
        idle("R6", 0, 0);
        // R7: staging write on the copy cycle is deferred
        cyc("R7", 1, 0, 32'h3, 0, 0);
        cyc("R7", 1, 3, 32'h1234_5678, 1, 3);
        idle("R7", 0, 3);
        cyc("R7", 1, 0, 32'h3, 0, 0);
        idle("R7", 1, 0);
        idle("R7", 0, 0);
        // R8: commit posted on the copy cycle stays pending
        cyc("R8", 1, 0, 32'h3, 0, 0);
        cyc("R8", 1, 0, 32'h3, 1, 0);
        idle("R8", 0, 0);
        idle("R8", 1, 0);
        idle("R8", 0, 0);
        // R9: clearing bit 1 does not cancel a pending commit
        cyc("R9", 1, 0, 32'h3, 0, 0);
        cyc("R9", 1, 0, 32'h1, 0, 0);
        idle("R9", 0, 0);
        idle("R9", 1, 0);
        idle("R9", 0, 0);
        // R10: unmapped addresses
        cyc("R10", 1, 12, 32'hDEAD_DEAD, 0, 12);
        idle("R10", 0, 9);
        idle("R10", 0, 15);
        // R3: free-running mode copies on every edge
        cyc("R3", 1, 0, 32'h0, 0, 0);
        cyc("R3", 1, 5, 32'h0505_0505, 0, 5);
        idle("R3", 1, 5);
        cyc("R3", 1, 5, 32'h0606_0606, 0, 5);
        idle("R3", 1, 5);
        idle("R3", 0, 0);
        // Random mix covering R2 R3 R4 R5 R7 R8 R9 R10
        begin
            logic vb = 0;
            for (int k = 0; k < 4000; k++) begin
                logic          we = ($urandom % 3) == 0;
                logic [AW-1:0] wa = (($urandom % 4) == 0) ? '0 : AW'($urandom);
                logic [DW-1:0] wd = $urandom;
                if (($urandom % 6) == 0) vb = ~vb;
                cyc("RND", we, wa, wd, vb, AW'($urandom));
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule